// File: doc/BRIEF.md
# FIFO Occupancy Flag Generator

This block turns a FIFO word count into the five status outputs a producer and a consumer need for flow control. Empty, full and half-full come straight from the count. Almost-empty and almost-full compare the count, or the free space, against two thresholds that can be changed at run time. Storage, pointers and the crossing of counts between clock domains are outside the block. It takes one count that is already valid in its own clock domain.

Each threshold has a preset value that is applied by a master reset. Software can replace the thresholds in two ways. A parallel path loads one threshold per strobe from a data bus. A serial path shifts both thresholds in, one bit per clock. A mode input selects how the two programmable flags are timed. They can either follow the count in the same cycle or be registered on the clock. A partial reset returns the load sequences and the registered flags to their start state and leaves the programmed thresholds unchanged.

Top module: `fifo_flag_gen`

## Requirements
- R1: `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` equals DEPTH.
- R2: `half_full` is 1 exactly when `level` is strictly greater than DEPTH/2.
- R3: `almost_empty` is 1 when `level` is less than or equal to the empty threshold. `almost_full` is 1 when DEPTH minus `level` is less than or equal to the full threshold. Both thresholds are unsigned OFS_W-bit values.
- R4: A master reset (`mrst_n` low) sets both thresholds to their presets, which are 127 by default. It also restarts both load sequences and forces the registered programmable flags to `almost_empty`=1 and `almost_full`=0.
- R5: Each clock with `ld_strobe` high loads `ld_data` into one threshold. The first strobe after any reset writes the empty threshold, the next writes the full threshold, and the target keeps alternating after that.
- R6: Each clock with `ser_en` high (and `ld_strobe` low) stores one bit of `ser_din`. Bit positions 0..OFS_W-1 of the sequence fill the empty threshold LSB first. Positions OFS_W..2*OFS_W-1 then fill the full threshold LSB first. After the last position the sequence returns to position 0.
- R7: When `ld_strobe` and `ser_en` are high in the same clock, only the parallel load takes place. The serial bit is discarded and the serial position does not advance.
- R8: With `flag_sync` at 0, `almost_empty` and `almost_full` follow `level` and the thresholds in the same cycle, with no clock edge needed.
- R9: With `flag_sync` at 1, `almost_empty` and `almost_full` change only at a rising clock edge. They show the value that R3 gives for the `level` sampled at that edge.
- R10: A partial reset (`prst_n` low) keeps both thresholds. It restarts both load sequences and forces the registered programmable flags to `almost_empty`=1 and `almost_full`=0.
- R11: `empty`, `full` and `half_full` depend only on `level`. They are never registered, whatever the value of `flag_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for loads and registered flags |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| flag_sync | input | 1 | 1 = registered programmable flags, 0 = flags follow the count directly |
| level | input | $clog2(DEPTH+1) | Current word count, 0 to DEPTH |
| ser_en | input | 1 | Serial threshold load enable |
| ser_din | input | 1 | Serial threshold data bit |
| ld_strobe | input | 1 | Parallel threshold load strobe |
| ld_data | input | OFS_W | Parallel threshold value |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals DEPTH |
| half_full | output | 1 | Count above half of DEPTH |
| almost_empty | output | 1 | Count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The bench sweeps every count from 0 to DEPTH under each threshold pair. This exposes off-by-one errors in the compares: a strict compare where an inclusive one is needed would drop the flag exactly at the threshold, and an inclusive half-full test would assert one word early. Loads are checked for ordering in three cases. A swapped serial order would place the thresholds in the wrong registers. A serial path that advances during a parallel strobe would shift every later bit. A sequence pointer that survives partial reset would send the next strobe to the full threshold. The registered mode is checked between a count change and the next edge, so flags that are not actually registered fail. A partial reset that reloads the presets is caught by the sweep after the reset.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

   // target of the next parallel load
   typedef enum logic {
      SEL_EMPTY_THR = 1'b0,
      SEL_FULL_THR  = 1'b1
   } thr_sel_e;

   // programmable flag lanes
   localparam int unsigned N_PFLAG = 2;
   localparam int unsigned PF_AE   = 0;
   localparam int unsigned PF_AF   = 1;

endpackage

// File: rtl/ffg_offset_regs.sv
module ffg_offset_regs
   import ffg_pkg::*;
#(
   parameter int unsigned OFS_W  = 10,
   parameter int unsigned DEF_AE = 127,
   parameter int unsigned DEF_AF = 127
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             ser_en,
   input  logic             ser_din,
   input  logic             ld_strobe,
   input  logic [OFS_W-1:0] ld_data,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs
);

   localparam int unsigned SER_BITS = 2 * OFS_W;
   localparam int unsigned SCW      = (SER_BITS > 1) ? $clog2(SER_BITS) : 1;
   localparam logic [OFS_W-1:0] DEF_AE_V = OFS_W'(DEF_AE);
   localparam logic [OFS_W-1:0] DEF_AF_V = OFS_W'(DEF_AF);
   localparam logic [SCW-1:0]   SER_LAST = SCW'(SER_BITS - 1);

   logic             seq_rst_n;
   thr_sel_e         par_sel;
   logic [SCW-1:0]   ser_pos;
   logic             ser_take;
   logic [OFS_W-1:0] ae_q, af_q;
   logic [OFS_W-1:0] ae_wen, af_wen;
   logic [OFS_W-1:0] ae_wdat, af_wdat;
   logic             par_ae, par_af;

   // sequencers restart on either reset
   assign seq_rst_n = mrst_n & prst_n;
   // parallel strobe takes the cycle; serial bit is dropped
   assign ser_take  = ser_en & ~ld_strobe;
   assign par_ae    = ld_strobe & (par_sel == SEL_EMPTY_THR);
   assign par_af    = ld_strobe & (par_sel == SEL_FULL_THR);

   always_ff @(posedge clk or negedge seq_rst_n) begin
      if (!seq_rst_n) begin
         par_sel <= SEL_EMPTY_THR;
      end else if (ld_strobe) begin
         par_sel <= (par_sel == SEL_EMPTY_THR) ? SEL_FULL_THR : SEL_EMPTY_THR;
      end
   end

   always_ff @(posedge clk or negedge seq_rst_n) begin
      if (!seq_rst_n) begin
         ser_pos <= '0;
      end else if (ser_take) begin
         ser_pos <= (ser_pos == SER_LAST) ? '0 : ser_pos + 1'b1;
      end
   end

   // per-bit write enables: one decode lane for each threshold bit
   for (genvar gi = 0; gi < OFS_W; gi++) begin : g_bit
      logic ae_ser_hit, af_ser_hit;
      assign ae_ser_hit  = ser_take & (ser_pos == SCW'(gi));
      assign af_ser_hit  = ser_take & (ser_pos == SCW'(OFS_W + gi));
      assign ae_wen[gi]  = par_ae | ae_ser_hit;
      assign af_wen[gi]  = par_af | af_ser_hit;
      assign ae_wdat[gi] = par_ae ? ld_data[gi] : ser_din;
      assign af_wdat[gi] = par_af ? ld_data[gi] : ser_din;
   end

   // thresholds: only master reset touches them
   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
         ae_q <= DEF_AE_V;
         af_q <= DEF_AF_V;
      end else begin
         ae_q <= (ae_q & ~ae_wen) | (ae_wdat & ae_wen);
         af_q <= (af_q & ~af_wen) | (af_wdat & af_wen);
      end
   end

   assign ae_ofs = ae_q;
   assign af_ofs = af_q;

endmodule

// File: rtl/ffg_level_cmp.sv
module ffg_level_cmp #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned OFS_W = 10,
   parameter int unsigned CW    = 11
) (
   input  logic [CW-1:0]    level,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [OFS_W-1:0] af_ofs,
   output logic             empty,
   output logic             full,
   output logic             half_full,
   output logic             ae_raw,
   output logic             af_raw
);

   localparam int unsigned XW = CW + 1;
   localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_V  = CW'(DEPTH / 2);

   logic [CW-1:0] free_words;

   assign free_words = DEPTH_V - level;

   assign empty     = (level == '0);
   assign full      = (level == DEPTH_V);
   assign half_full = (level > HALF_V);
   assign ae_raw    = (XW'(level) <= XW'(ae_ofs));
   assign af_raw    = (XW'(free_words) <= XW'(af_ofs));

endmodule

// File: rtl/ffg_flag_timing.sv
module ffg_flag_timing #(
   parameter int unsigned N       = 2,
   parameter logic [N-1:0] RST_PAT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flag_sync,
   input  logic [N-1:0] raw,
   output logic [N-1:0] flag
);

   for (genvar gf = 0; gf < N; gf++) begin : g_lane
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_PAT[gf];
         else        q <= raw[gf];
      end
      assign flag[gf] = flag_sync ? q : raw[gf];
   end

endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
   import ffg_pkg::*;
#(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned OFS_W  = 10,
   parameter int unsigned DEF_AE = 127,
   parameter int unsigned DEF_AF = 127
) (
   input  logic                       clk,
   input  logic                       mrst_n,
   input  logic                       prst_n,
   input  logic                       flag_sync,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   input  logic                       ser_en,
   input  logic                       ser_din,
   input  logic                       ld_strobe,
   input  logic [OFS_W-1:0]           ld_data,
   output logic                       empty,
   output logic                       full,
   output logic                       half_full,
   output logic                       almost_empty,
   output logic                       almost_full
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [N_PFLAG-1:0] PF_RST = N_PFLAG'(1) << PF_AE;

   if (DEPTH < 4) begin : g_chk_depth
      $error("fifo_flag_gen: DEPTH must be at least 4");
   end
   if (OFS_W > CW) begin : g_chk_ofs_w
      $error("fifo_flag_gen: OFS_W wider than the count");
   end
   if (DEF_AE >= (1 << OFS_W) || DEF_AF >= (1 << OFS_W)) begin : g_chk_def
      $error("fifo_flag_gen: preset threshold does not fit OFS_W");
   end

   logic [OFS_W-1:0]   ae_ofs, af_ofs;
   logic               ae_raw, af_raw;
   logic               flag_rst_n;
   logic [N_PFLAG-1:0] pf_raw, pf_out;

   assign flag_rst_n = mrst_n & prst_n;

   ffg_offset_regs #(
      .OFS_W (OFS_W),
      .DEF_AE(DEF_AE),
      .DEF_AF(DEF_AF)
   ) u_ofs (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .prst_n   (prst_n),
      .ser_en   (ser_en),
      .ser_din  (ser_din),
      .ld_strobe(ld_strobe),
      .ld_data  (ld_data),
      .ae_ofs   (ae_ofs),
      .af_ofs   (af_ofs)
   );

   ffg_level_cmp #(
      .DEPTH(DEPTH),
      .OFS_W(OFS_W),
      .CW   (CW)
   ) u_cmp (
      .level    (level),
      .ae_ofs   (ae_ofs),
      .af_ofs   (af_ofs),
      .empty    (empty),
      .full     (full),
      .half_full(half_full),
      .ae_raw   (ae_raw),
      .af_raw   (af_raw)
   );

   assign pf_raw[PF_AE] = ae_raw;
   assign pf_raw[PF_AF] = af_raw;

   ffg_flag_timing #(
      .N      (N_PFLAG),
      .RST_PAT(PF_RST)
   ) u_tim (
      .clk      (clk),
      .rst_n    (flag_rst_n),
      .flag_sync(flag_sync),
      .raw      (pf_raw),
      .flag     (pf_out)
   );

   assign almost_empty = pf_out[PF_AE];
   assign almost_full  = pf_out[PF_AF];

endmodule

// File: rtl/ffg_checker.sv
module ffg_checker #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned OFS_W = 10
) (
   input logic                       clk,
   input logic                       mrst_n,
   input logic                       prst_n,
   input logic                       flag_sync,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic                       ser_en,
   input logic                       ld_strobe,
   input logic                       empty,
   input logic                       full,
   input logic                       half_full,
   input logic                       almost_empty,
   input logic                       almost_full,
   input logic [OFS_W-1:0]           ae_ofs,
   input logic [OFS_W-1:0]           af_ofs
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam int unsigned XW = CW + 1;

   p_level_range_r1: assert property (@(posedge clk) disable iff (!mrst_n)
      XW'(level) <= XW'(DEPTH));

   p_empty_full_excl_r1: assert property (@(posedge clk) disable iff (!mrst_n)
      !(empty && full));

   p_half_not_empty_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      half_full |-> !empty);

   p_direct_empty_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      (!flag_sync && empty) |-> almost_empty);

   p_direct_full_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      (!flag_sync && full) |-> almost_full);

   p_reg_lag_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      (flag_sync && $past(flag_sync) && prst_n && $past(prst_n))
      |-> (almost_empty == (XW'($past(level)) <= XW'($past(ae_ofs)))));

   p_prst_flags_r10: assert property (@(posedge clk) disable iff (!mrst_n)
      (!prst_n && flag_sync) |-> (almost_empty && !almost_full));

   p_thr_hold_r10: assert property (@(posedge clk) disable iff (!mrst_n)
      (!$past(ld_strobe) && !$past(ser_en)) |-> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

bind fifo_flag_gen ffg_checker #(
   .DEPTH(DEPTH),
   .OFS_W(OFS_W)
) u_ffg_chk (
   .clk         (clk),
   .mrst_n      (mrst_n),
   .prst_n      (prst_n),
   .flag_sync   (flag_sync),
   .level       (level),
   .ser_en      (ser_en),
   .ld_strobe   (ld_strobe),
   .empty       (empty),
   .full        (full),
   .half_full   (half_full),
   .almost_empty(almost_empty),
   .almost_full (almost_full),
   .ae_ofs      (ae_ofs),
   .af_ofs      (af_ofs)
);

// File: tb/test_fifo_flag_gen.sv
module test_fifo_flag_gen;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 256;
   localparam int OFS_W      = 8;
   localparam int CW         = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             mrst_n = 1'b0;
   logic             prst_n = 1'b1;
   logic             flag_sync = 1'b0;
   logic [CW-1:0]    level = '0;
   logic             ser_en = 1'b0;
   logic             ser_din = 1'b0;
   logic             ld_strobe = 1'b0;
   logic [OFS_W-1:0] ld_data = '0;
   logic             empty, full, half_full, almost_empty, almost_full;

   int n_cmp = 0;
   int n_bad = 0;
   int m_ae  = 127;
   int m_af  = 127;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_flag_gen #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_fifo_flag_gen (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .flag_sync(flag_sync),
      .level(level), .ser_en(ser_en), .ser_din(ser_din),
      .ld_strobe(ld_strobe), .ld_data(ld_data),
      .empty(empty), .full(full), .half_full(half_full),
      .almost_empty(almost_empty), .almost_full(almost_full)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FIFO-FLAG FAIL %s: actual %0d expected %0d (level %0d)", req, act, exp, level);
      end
   endtask

   function automatic int x_ae(input int l); return (l <= m_ae) ? 1 : 0; endfunction
   function automatic int x_af(input int l); return ((DEPTH - l) <= m_af) ? 1 : 0; endfunction

   // full-range sweep with direct flag timing: R1 R2 R3 R8 R11
   task automatic sweep_direct(input string tag);
      flag_sync = 1'b0;
      for (int l = 0; l <= DEPTH; l++) begin
         @(negedge clk);
         level = CW'(l);
         #1;
         chk({tag, " R1 empty"}, int'(empty), (l == 0) ? 1 : 0);
         chk({tag, " R1 full"},  int'(full),  (l == DEPTH) ? 1 : 0);
         chk({tag, " R2 half"},  int'(half_full), (l > DEPTH/2) ? 1 : 0);
         chk({tag, " R3 R8 ae"}, int'(almost_empty), x_ae(l));
         chk({tag, " R3 R8 af"}, int'(almost_full),  x_af(l));
      end
   endtask

   task automatic par_load(input int v);
      @(negedge clk);
      ld_strobe = 1'b1; ld_data = OFS_W'(v);
      @(negedge clk);
      ld_strobe = 1'b0;
   endtask

   task automatic ser_bits(input logic [2*OFS_W-1:0] bits, input int lo, input int hi);
      for (int b = lo; b <= hi; b++) begin
         @(negedge clk);
         ser_en = 1'b1; ser_din = bits[b];
      end
      @(negedge clk);
      ser_en = 1'b0;
   endtask

   task automatic pulse_prst();
      @(negedge clk); prst_n = 1'b0;
      @(negedge clk); prst_n = 1'b1;
   endtask

   task automatic pulse_mrst();
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FIFO-FLAG FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int prev_ae, prev_af;
      // reset state, registered mode: R4
      flag_sync = 1'b1;
      level = CW'(200);
      repeat (3) @(negedge clk);
      #1;
      chk("R4 reset ae", int'(almost_empty), 1);
      chk("R4 reset af", int'(almost_full), 0);
      chk("R11 reset half", int'(half_full), 1);
      mrst_n = 1'b1;
      level = '0;

      // presets 127/127: R4
      sweep_direct("preset");

      // registered timing: R9 R11
      flag_sync = 1'b1;
      @(negedge clk); level = '0;
      @(posedge clk); #1;
      prev_ae = x_ae(0); prev_af = x_af(0);
      for (int l = 0; l <= DEPTH; l += 3) begin
         @(negedge clk);
         level = CW'(l);
         #1;
         chk("R9 hold ae", int'(almost_empty), prev_ae);
         chk("R9 hold af", int'(almost_full), prev_af);
         chk("R11 direct empty", int'(empty), (l == 0) ? 1 : 0);
         @(posedge clk); #1;
         chk("R9 update ae", int'(almost_empty), x_ae(l));
         chk("R9 update af", int'(almost_full), x_af(l));
         prev_ae = x_ae(l); prev_af = x_af(l);
      end

      // parallel loads: R5
      par_load(10); par_load(20);
      m_ae = 10; m_af = 20;
      sweep_direct("R5 par");

      // serial load, empty threshold first, LSB first: R6
      ser_bits({8'd3, 8'd200}, 0, 2*OFS_W-1);
      m_ae = 200; m_af = 3;
      sweep_direct("R6 ser");
      // wrap back to position 0
      ser_bits({8'd66, 8'd55}, 0, 2*OFS_W-1);
      m_ae = 55; m_af = 66;
      sweep_direct("R6 wrap");

      // partial reset keeps thresholds, restarts parallel order: R10
      par_load(33);            // goes to empty threshold, next target full
      m_ae = 33;
      flag_sync = 1'b1;
      @(negedge clk); level = CW'(250); prst_n = 1'b0;
      @(posedge clk); #1;
      chk("R10 prst ae", int'(almost_empty), 1);
      chk("R10 prst af", int'(almost_full), 0);
      @(negedge clk); prst_n = 1'b1;
      @(posedge clk); #1;
      chk("R10 after prst af", int'(almost_full), x_af(250));
      par_load(44);            // must hit the empty threshold again
      m_ae = 44;
      sweep_direct("R10 keep");

      // serial order restarts after partial reset as well: R10
      ser_bits({8'd9, 8'd7}, 0, 3);
      pulse_prst();
      ser_bits({8'd12, 8'd150}, 0, 2*OFS_W-1);
      m_ae = 150; m_af = 12;
      sweep_direct("R10 ser");

      // strobe and serial in the same cycle: R7
      pulse_prst();
      ser_bits({8'd77, 8'h5A}, 0, 3);
      @(negedge clk);
      ser_en = 1'b1; ser_din = 1'b1; ld_strobe = 1'b1; ld_data = 8'hCA;
      @(negedge clk);
      ld_strobe = 1'b0; ser_en = 1'b0;
      ser_bits({8'd77, 8'h5A}, 4, 2*OFS_W-1);
      par_load(90);            // second strobe -> full threshold
      m_ae = 8'h5A; m_af = 90;
      sweep_direct("R7 both");

      // master reset restores presets: R4
      pulse_mrst();
      m_ae = 127; m_af = 127;
      sweep_direct("R4 mrst");
      par_load(5);             // parallel order restarted by master reset
      m_ae = 5;
      sweep_direct("R4 order");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule